// File: doc/BRIEF.md
# Pointer-Based Data Address Generator with Linear, Circular and Bit-Reversed Post-Update

This block produces data-memory addresses for a signal-processing datapath. It holds one pointer register and returns the address for the current access on `addrOut`. When `stepEn` is asserted, the pointer moves on after the access. The size of each move is a signed step scaled by a power of two. The addressing mode decides how the pointer moves.

There are three modes. In linear mode the pointer simply adds the scaled step. In circular mode the pointer stays inside a window that starts at `baseAddr` and holds `bufLen` words. A filter can therefore write each new sample over the oldest one and never shift its delay line. In bit-reversed mode an internal sample counter runs through 0..N-1, and the address is the base plus that count with its low log2(N) bits mirrored. This is the reordered sequence an FFT stage reads or writes.

Software chooses the mode and the start pointer with a synchronous load. Memory, instruction decode and filter arithmetic are all outside this block.

Top module: `agu_ptr`

## Requirements
- R1: After reset the pointer is 0 and the mode is linear, so `addrOut` is 0 and a step of +1 yields address 1.
- R2: `loadEn` sets the pointer to `loadVal`, clears the bit-reversal counter and latches `modeSel` (0 linear, 1 circular, 2 bit-reversed, 3 treated as linear). When `loadEn` and `stepEn` are high in the same cycle, the load wins.
- R3: In linear and circular modes `addrOut` equals the pointer. A `stepEn` pulse changes `addrOut` only from the next cycle on.
- R4: The scaled offset is `stepVal` (signed) times 2^`stepShift`. In linear mode each `stepEn` adds it to the pointer modulo 2^32.
- R5: In circular mode with K=`bufLen`≥2, a pointer inside [base, base+K-1] and |offset|<K, a forward step gives base + ((ptr-base+offset) mod K), wrapping past base+K-1 to the window start.
- R6: In circular mode a backward step that passes below the base re-enters from the top, so a step of -1 at the base gives base+K-1.
- R7: In circular mode with `bufLen` equal to 0 or 1, `stepEn` sets the pointer to `baseAddr`.
- R8: In bit-reversed mode `addrOut` = `baseAddr` + the low L=`fftLog2` bits of the counter in reversed order. Each `stepEn` raises the counter by one modulo 2^L, and `stepVal` has no effect. For L=3 the sequence of offsets is 0,4,2,6,1,5,3,7,0.
- R9: With neither `loadEn` nor `stepEn` asserted, the address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Load pointer and mode |
| loadVal | input | 32 | Pointer value to load |
| modeSel | input | 2 | Mode latched on load |
| baseAddr | input | 32 | Window / table base |
| bufLen | input | 32 | Circular window length K |
| stepVal | input | 16 | Signed step |
| stepShift | input | 2 | Step scale exponent (x1,x2,x4,x8) |
| fftLog2 | input | 4 | log2 of FFT size for bit reversal (0..10) |
| stepEn | input | 1 | Post-update strobe |
| addrOut | output | 32 | Address of the current access |

## Verification
A corrupted pointer or wrap decision is visible on `addrOut` in the cycle right after the faulty `stepEn`, because the output is read straight from the pointer register. A wrong bit-reversal counter shows up one step later as a wrong permutation element, and a counter that does not wrap modulo 2^L shows up when the sequence should return to offset 0. Mode-latch faults appear as soon as the next step takes the wrong arithmetic path.

// File: rtl/agu_pkg.sv
`timescale 1ns/1ps
package agu_pkg;
  typedef enum logic [1:0] {
    MODE_LIN  = 2'd0,
    MODE_CIRC = 2'd1,
    MODE_REV  = 2'd2,
    MODE_RSVD = 2'd3
  } agu_mode_e;

  typedef struct packed {
    logic load;
    logic advLin;
    logic advCirc;
    logic advRev;
    logic selRev;
  } agu_strobe_t;
endpackage

// File: rtl/agu_ctrl.sv
`timescale 1ns/1ps
module agu_ctrl
  import agu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        loadEn,
  input  logic [1:0]  modeSel,
  input  logic        stepEn,
  output agu_strobe_t strobe
);
  agu_mode_e modeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_LIN;
    end else if (loadEn) begin
      modeQ <= (agu_mode_e'(modeSel) == MODE_RSVD) ? MODE_LIN : agu_mode_e'(modeSel);
    end
  end

  logic advAny;
  assign advAny = stepEn && !loadEn;

  always_comb begin
    strobe         = '0;
    strobe.load    = loadEn;
    strobe.advLin  = advAny && (modeQ == MODE_LIN);
    strobe.advCirc = advAny && (modeQ == MODE_CIRC);
    strobe.advRev  = advAny && (modeQ == MODE_REV);
    strobe.selRev  = (modeQ == MODE_REV);
  end

  // R2: load has priority, so at most one strobe acts per cycle
  a_r2_one_action: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.load, strobe.advLin, strobe.advCirc, strobe.advRev}));

  // R1 / R2: the reserved code never leaves the mode register
  a_r2_no_rsvd: assert property (@(posedge clk) disable iff (!rstN)
    modeQ != MODE_RSVD);
endmodule

// File: rtl/agu_dpath.sv
`timescale 1ns/1ps
module agu_dpath
  import agu_pkg::*;
#(
  parameter int AW      = 32,
  parameter int SW      = 16,
  parameter int SHW     = 2,
  parameter int MAX_LOG = 10,
  parameter int LW      = $clog2(MAX_LOG + 1)
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  agu_strobe_t          strobe,
  input  logic [AW-1:0]        loadVal,
  input  logic [AW-1:0]        baseAddr,
  input  logic [AW-1:0]        bufLen,
  input  logic signed [SW-1:0] stepVal,
  input  logic [SHW-1:0]       stepShift,
  input  logic [LW-1:0]        fftLog2,
  output logic [AW-1:0]        addrOut
);
  localparam int CW = MAX_LOG;

  logic [AW-1:0] ptrQ;
  logic [CW-1:0] cntQ;

  // scaled signed offset
  logic signed [AW-1:0] stepExt, scaled;
  assign stepExt = AW'(stepVal);
  assign scaled  = stepExt <<< stepShift;

  // circular arithmetic on the offset inside the window
  logic [AW-1:0]        offs;
  logic signed [AW:0]   sumS, lenS, wrapS;
  logic [AW-1:0]        nextCirc;
  logic                 smallLen;
  assign offs     = ptrQ - baseAddr;
  assign lenS     = $signed({1'b0, bufLen});
  assign sumS     = $signed({1'b0, offs}) + $signed({scaled[AW-1], scaled});
  assign smallLen = (bufLen <= AW'(1));

  always_comb begin
    if (sumS < 0)           wrapS = sumS + lenS;
    else if (sumS >= lenS)  wrapS = sumS - lenS;
    else                    wrapS = sumS;
    nextCirc = smallLen ? baseAddr : (baseAddr + wrapS[AW-1:0]);
  end

  // bit-reversed index of the low fftLog2 counter bits
  logic [CW:0]   maskWide;
  logic [CW-1:0] cntMask, cntFull, revL;
  assign maskWide = ((CW+1)'(1) << fftLog2) - (CW+1)'(1);
  assign cntMask  = maskWide[CW-1:0];

  generate
    for (genvar i = 0; i < CW; i++) begin : g_rev
      assign cntFull[i] = cntQ[CW-1-i];
    end
  endgenerate
  assign revL = cntFull >> (LW'(CW) - fftLog2);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
      cntQ <= '0;
    end else if (strobe.load) begin
      ptrQ <= loadVal;
      cntQ <= '0;
    end else if (strobe.advLin) begin
      ptrQ <= ptrQ + scaled;
    end else if (strobe.advCirc) begin
      ptrQ <= nextCirc;
    end else if (strobe.advRev) begin
      cntQ <= (cntQ + CW'(1)) & cntMask;
    end
  end

  assign addrOut = strobe.selRev ? (baseAddr + AW'(revL)) : ptrQ;

  // R2: a load is seen at the pointer one cycle later
  a_r2_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.load |=> (ptrQ == $past(loadVal)) && (cntQ == '0));

  // R4: linear step moves by the scaled offset
  a_r4_linear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.advLin |=> (ptrQ - $past(ptrQ)) == $past(scaled));

  // R5 / R6: a circular step from inside the window stays inside it
  a_r5_window: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advCirc && !smallLen && (offs < bufLen)) |=>
      ((ptrQ - $past(baseAddr)) < $past(bufLen)));

  // R7: degenerate window pins the pointer to the base
  a_r7_small_k: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advCirc && smallLen) |=> ptrQ == $past(baseAddr));

  // R9: without an action nothing moves
  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.load || strobe.advLin || strobe.advCirc || strobe.advRev) |=>
      ($stable(ptrQ) && $stable(cntQ)));
endmodule

// File: rtl/agu_ptr.sv
`timescale 1ns/1ps
module agu_ptr
  import agu_pkg::*;
#(
  parameter int AW      = 32,
  parameter int SW      = 16,
  parameter int SHW     = 2,
  parameter int MAX_LOG = 10,
  parameter int LW      = $clog2(MAX_LOG + 1)
)(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 loadEn,
  input  logic [AW-1:0]        loadVal,
  input  logic [1:0]           modeSel,
  input  logic [AW-1:0]        baseAddr,
  input  logic [AW-1:0]        bufLen,
  input  logic signed [SW-1:0] stepVal,
  input  logic [SHW-1:0]       stepShift,
  input  logic [LW-1:0]        fftLog2,
  input  logic                 stepEn,
  output logic [AW-1:0]        addrOut
);
  agu_strobe_t strobe;

  agu_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .loadEn  (loadEn),
    .modeSel (modeSel),
    .stepEn  (stepEn),
    .strobe  (strobe)
  );

  agu_dpath #(
    .AW(AW), .SW(SW), .SHW(SHW), .MAX_LOG(MAX_LOG), .LW(LW)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .loadVal   (loadVal),
    .baseAddr  (baseAddr),
    .bufLen    (bufLen),
    .stepVal   (stepVal),
    .stepShift (stepShift),
    .fftLog2   (fftLog2),
    .addrOut   (addrOut)
  );
endmodule

// File: tb/agu_ptr_test.sv
`timescale 1ns/1ps
module agu_ptr_test;
  logic               clk = 1'b0;
  logic               rstN;
  logic               loadEn;
  logic [31:0]        loadVal;
  logic [1:0]         modeSel;
  logic [31:0]        baseAddr;
  logic [31:0]        bufLen;
  logic signed [15:0] stepVal;
  logic [1:0]         stepShift;
  logic [3:0]         fftLog2;
  logic               stepEn;
  logic [31:0]        addrOut;

  int nRun = 0;
  int nFail = 0;

  always #2.5 clk = ~clk;

  agu_ptr uut (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .loadVal(loadVal),
    .modeSel(modeSel), .baseAddr(baseAddr), .bufLen(bufLen),
    .stepVal(stepVal), .stepShift(stepShift), .fftLog2(fftLog2),
    .stepEn(stepEn), .addrOut(addrOut)
  );

  task automatic chk(input logic [31:0] exp, input string tag);
    nRun++;
    if (addrOut !== exp) begin
      nFail++;
      $display("FAIL %s: addrOut=%0d expected %0d", tag, addrOut, exp);
    end
  endtask

  // one clock: inputs driven at negedge, sampled at the next negedge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    loadEn = 1'b0;
    stepEn = 1'b0;
  endtask

  task automatic doLoad(input logic [31:0] v, input logic [1:0] m);
    loadVal = v; modeSel = m; loadEn = 1'b1;
    tick();
  endtask

  task automatic doStep(input int s, input logic [1:0] sh);
    stepVal = 16'(s); stepShift = sh; stepEn = 1'b1;
    tick();
  endtask

  function automatic logic [31:0] mirror(input int v, input int l);
    logic [31:0] r = '0;
    for (int i = 0; i < l; i++) r[l-1-i] = v[i];
    return r;
  endfunction

  task automatic t_reset();
    chk(32'd0, "R1 reset address");
    doStep(1, 2'd0);
    chk(32'd1, "R1 linear after reset");
  endtask

  task automatic t_linear();
    doLoad(32'd1000, 2'd0);
    chk(32'd1000, "R2 load linear");
    stepVal = 16'sd3; stepShift = 2'd3; stepEn = 1'b1;
    #0.5 chk(32'd1000, "R3 current address before update");
    tick();
    chk(32'd1024, "R4 step 3 scaled x8");
    doStep(-5, 2'd1);
    chk(32'd1014, "R4 negative step x2");
    doLoad(32'd2, 2'd3);
    doStep(-4, 2'd0);
    chk(32'hFFFF_FFFE, "R2 mode 3 linear, R4 wrap 2^32");
  endtask

  task automatic t_loadPrio();
    doLoad(32'd50, 2'd0);
    loadVal = 32'd70; modeSel = 2'd0; loadEn = 1'b1;
    stepVal = 16'sd9; stepShift = 2'd0; stepEn = 1'b1;
    tick();
    chk(32'd70, "R2 load beats step");
  endtask

  task automatic t_circFwd();
    baseAddr = 32'd100; bufLen = 32'd5;
    doLoad(32'd100, 2'd1);
    doStep(2, 2'd0); chk(32'd102, "R5 circ 102");
    doStep(2, 2'd0); chk(32'd104, "R5 circ 104");
    doStep(2, 2'd0); chk(32'd101, "R5 circ wrap 101");
    doStep(2, 2'd0); chk(32'd103, "R5 circ 103");
    doStep(1, 2'd1); chk(32'd100, "R5 circ wrap to base scaled");
  endtask

  task automatic t_circBack();
    baseAddr = 32'd100; bufLen = 32'd5;
    doLoad(32'd100, 2'd1);
    doStep(-1, 2'd0); chk(32'd104, "R6 back wrap to top");
    doStep(-3, 2'd0); chk(32'd101, "R6 back inside");
    doStep(-3, 2'd0); chk(32'd103, "R6 back wrap 103");
  endtask

  task automatic t_smallK();
    baseAddr = 32'd300; bufLen = 32'd1;
    doLoad(32'd305, 2'd1);
    doStep(1, 2'd0); chk(32'd300, "R7 K=1 holds base");
    bufLen = 32'd0;
    doStep(-2, 2'd2); chk(32'd300, "R7 K=0 holds base");
  endtask

  task automatic t_bitrev3();
    int seq [9] = '{0, 4, 2, 6, 1, 5, 3, 7, 0};
    baseAddr = 32'd512; fftLog2 = 4'd3;
    doLoad(32'd9, 2'd2);
    chk(32'd512, "R8 bitrev start");
    for (int i = 1; i < 9; i++) begin
      doStep(77, 2'd3);
      chk(32'd512 + 32'(seq[i]), "R8 bitrev L3 element");
    end
  endtask

  task automatic t_bitrev4();
    baseAddr = 32'd0; fftLog2 = 4'd4;
    doLoad(32'd0, 2'd2);
    for (int i = 1; i < 17; i++) begin
      doStep(1, 2'd0);
      chk(mirror(i % 16, 4), "R8 bitrev L4 element");
    end
  endtask

  task automatic t_hold();
    doLoad(32'd4242, 2'd0);
    stepVal = 16'sd7;
    for (int i = 0; i < 3; i++) tick();
    chk(32'd4242, "R9 hold linear");
    baseAddr = 32'd800; fftLog2 = 4'd3;
    doLoad(32'd0, 2'd2);
    doStep(1, 2'd0);
    for (int i = 0; i < 3; i++) tick();
    chk(32'd804, "R9 hold bitrev");
  endtask

  initial begin
    #1_000_000;
    nFail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    rstN = 1'b0; loadEn = 1'b0; loadVal = '0; modeSel = '0;
    baseAddr = '0; bufLen = '0; stepVal = '0; stepShift = '0;
    fftLog2 = '0; stepEn = 1'b0;
    @(negedge clk); @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_linear();
    t_loadPrio();
    t_circFwd();
    t_circBack();
    t_smallK();
    t_bitrev3();
    t_bitrev4();
    t_hold();
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule